// File: doc/BRIEF.md
# Extended GPIO Bank with Wake Events

This block is an eight-pin general purpose I/O bank controlled through a small register port (address, write data, write strobe, read data). Every pin has its own settings for direction, output drive (push-pull or open-drain), input polarity, and input sensing. Input sensing is either level mode, where the status follows the pin, or edge mode, where the status bit latches until software clears it.

Any pin can be enabled to pull an active-low power-management wake output. Pins 6 down to 3 are shared with a secondary asynchronous serial port. While that port is enabled, it drives those pads and takes precedence over the GPIO settings, and the GPIO input logic treats those pins as inactive.

Inputs pass through a two-flop synchronizer before polarity and detection are applied. All registers reset to zero, so after reset every pin is an active-high, level-sensed input with no wake source.

Top module: `ext_gpio_bank`

## Requirements
- R1: After reset, every register reads 0 (raw reads the synchronized pins), pad_oe is 0 and wake_n is 1.
- R2: Register addresses are: 0 direction (1 = output), 1 output data, 2 polarity (1 = active low), 3 sense mode (1 = edge), 4 open-drain select, 5 wake enable. Each of these reads back what was last written. A write to address 7 (raw pin value, read-only) has no effect on any register or output.
- R3: For a GPIO-owned pin with direction 1 and open-drain 0, pad_oe is 1 and pad_out equals the output data bit. With direction 0, pad_oe is 0.
- R4: For a GPIO-owned output pin in open-drain mode, output data 0 gives pad_oe 1 with pad_out 0. Output data 1 gives pad_oe 0. Such a pin never drives a high level.
- R5: The active value of a pin is its synchronized input XOR its polarity bit. In level mode, status bit i (address 6) reads this active value directly and is not latched. The pin path has two register stages.
- R6: In edge mode, a change of the active value from 0 to 1 sets status bit i. The bit stays set after the input returns to inactive.
- R7: Writing 1 to a bit at address 6 clears that sticky bit. Writing 0 leaves it unchanged.
- R8: If an edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: wake_n is 0 exactly while some bit has both status 1 and wake enable 1.
- R10: While ser_en is 1, pins 6..3 take pad_out from ser_out and pad_oe from ser_oe (bit 0 maps to pin 3), and the active value of those pins is forced to 0.
- R11: Pins 7 and 2..0 behave the same whatever the value of ser_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| ser_en | input | 1 | Secondary serial port owns pins 6..3 |
| ser_out | input | 4 | Serial port pad output values |
| ser_oe | input | 4 | Serial port pad output enables |
| wake_n | output | 1 | Active-low wake event |

## Verification
A sticky bit can see a new edge and a software clear in the same cycle. This collision is provoked directly. An inactive-to-active change is placed on pin 0, and the write-one-to-clear is held across the exact edge where the synchronized change reaches the detector, which is the third rising edge after the pad changes. The status read that follows must still show the bit set, and a later clear with no edge present must empty it. Random traffic then applies exactly one change per step (a register write, a pad change, or a serial enable toggle), so the bench model can predict edges without ambiguity.

// File: rtl/egp_pkg.sv
// Shared definitions for the extended GPIO bank: register address codes.
package egp_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_DIR  = 3'd0,
        A_DOUT = 3'd1,
        A_POL  = 3'd2,
        A_MODE = 3'd3,
        A_ODRN = 3'd4,
        A_WAKE = 3'd5,
        A_STAT = 3'd6,
        A_RAW  = 3'd7
    } egp_addr_e;
endpackage

// File: rtl/egp_sync.sv
// Two-stage synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module egp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_out  <= '0;
        end else begin
            meta_q <= d_in;
            d_out  <= meta_q;
        end
    end
endmodule

// File: rtl/egp_detect.sv
// Per-pin polarity, level/edge sensing and sticky status.
// Assumes pin_sync is already synchronous. gate forces a pin inactive.
// An edge beats a clear on the same bit in the same cycle.
module egp_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] mode_edge,
    input  logic [NPINS-1:0] gate,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] status_view,
    output logic [NPINS-1:0] sticky,
    output logic [NPINS-1:0] edge_hit
);
    logic [NPINS-1:0] act;
    logic [NPINS-1:0] act_q;

    // Active value after polarity and ownership gating.
    always_comb act = (pin_sync ^ pol) & ~gate;

    // Remember the previous active value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Rising active edge, only in edge mode.
        always_comb edge_hit[i] = mode_edge[i] & act[i] & ~act_q[i];

        // Sticky bit: set by an edge, cleared by a write of 1, edge first.
        always_ff @(posedge clk) begin
            if (!rst_n)           sticky[i] <= 1'b0;
            else if (edge_hit[i]) sticky[i] <= 1'b1;
            else if (clr_vec[i])  sticky[i] <= 1'b0;
        end

        // Visible status: latched in edge mode, live in level mode.
        always_comb status_view[i] = mode_edge[i] ? sticky[i] : act[i];
    end
endmodule

// File: rtl/egp_pad_drv.sv
// Pad drive per pin: push-pull or open-drain GPIO, with serial override
// on the shared window [SER_LO +: SER_W]. Purely combinational.
module egp_pad_drv #(
    parameter int NPINS  = 8,
    parameter int SER_W  = 4,
    parameter int SER_LO = 3
) (
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] odrn,
    input  logic             ser_en,
    input  logic [SER_W-1:0] ser_out,
    input  logic [SER_W-1:0] ser_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    logic [NPINS-1:0] g_out;
    logic [NPINS-1:0] g_oe;

    // GPIO drive: open-drain drives only low, releases for a 1.
    always_comb begin
        g_out = dout & ~odrn;
        g_oe  = dir & ~(odrn & dout);
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        if (i >= SER_LO && i < SER_LO + SER_W) begin : g_shared
            // Shared pin: the serial port wins while enabled.
            always_comb begin
                pad_out[i] = ser_en ? ser_out[i-SER_LO] : g_out[i];
                pad_oe[i]  = ser_en ? ser_oe[i-SER_LO]  : g_oe[i];
            end
        end else begin : g_plain
            // Dedicated pin: always GPIO.
            always_comb begin
                pad_out[i] = g_out[i];
                pad_oe[i]  = g_oe[i];
            end
        end
    end
endmodule

// File: rtl/ext_gpio_bank.sv
// Extended GPIO bank top: configuration registers, read mux, wake output.
// Assumes register writes are single-cycle strobes; reads are combinational.
module ext_gpio_bank #(
    parameter int NPINS  = 8,
    parameter int SER_W  = 4,
    parameter int SER_LO = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [egp_pkg::REG_AW-1:0] reg_addr,
    input  logic [NPINS-1:0]          reg_wdata,
    input  logic                      reg_we,
    output logic [NPINS-1:0]          reg_rdata,
    input  logic [NPINS-1:0]          pad_in,
    output logic [NPINS-1:0]          pad_out,
    output logic [NPINS-1:0]          pad_oe,
    input  logic                      ser_en,
    input  logic [SER_W-1:0]          ser_out,
    input  logic [SER_W-1:0]          ser_oe,
    output logic                      wake_n
);
    import egp_pkg::*;

    localparam logic [NPINS-1:0] SER_MASK = NPINS'((2 ** SER_W - 1) << SER_LO);

    logic [NPINS-1:0] dir_q, dout_q, pol_q, mode_q, odrn_q, wake_q;
    logic [NPINS-1:0] pin_sync, status_view, sticky, edge_hit, clr_vec, gate;
    egp_addr_e        addr_e;

    // Decode the address into the register enum.
    always_comb addr_e = egp_addr_e'(reg_addr);

    // Configuration registers, all reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
            mode_q <= '0;
            odrn_q <= '0;
            wake_q <= '0;
        end else if (reg_we) begin
            case (addr_e)
                A_DIR:   dir_q  <= reg_wdata;
                A_DOUT:  dout_q <= reg_wdata;
                A_POL:   pol_q  <= reg_wdata;
                A_MODE:  mode_q <= reg_wdata;
                A_ODRN:  odrn_q <= reg_wdata;
                A_WAKE:  wake_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Clear strobes for the sticky bits, and gating of serial-owned inputs.
    always_comb begin
        clr_vec = (reg_we && addr_e == A_STAT) ? reg_wdata : '0;
        gate    = SER_MASK & {NPINS{ser_en}};
    end

    // Read mux.
    always_comb begin
        case (addr_e)
            A_DIR:   reg_rdata = dir_q;
            A_DOUT:  reg_rdata = dout_q;
            A_POL:   reg_rdata = pol_q;
            A_MODE:  reg_rdata = mode_q;
            A_ODRN:  reg_rdata = odrn_q;
            A_WAKE:  reg_rdata = wake_q;
            A_STAT:  reg_rdata = status_view;
            default: reg_rdata = pin_sync;
        endcase
    end

    // Wake request while any enabled pin reports an event.
    always_comb wake_n = ~|(status_view & wake_q);

    egp_sync #(.W(NPINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pin_sync)
    );

    egp_detect #(.NPINS(NPINS)) det_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_sync    (pin_sync),
        .pol         (pol_q),
        .mode_edge   (mode_q),
        .gate        (gate),
        .clr_vec     (clr_vec),
        .status_view (status_view),
        .sticky      (sticky),
        .edge_hit    (edge_hit)
    );

    egp_pad_drv #(.NPINS(NPINS), .SER_W(SER_W), .SER_LO(SER_LO)) drv_i (
        .dir     (dir_q),
        .dout    (dout_q),
        .odrn    (odrn_q),
        .ser_en  (ser_en),
        .ser_out (ser_out),
        .ser_oe  (ser_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/egp_checker.sv
// Assertion checker for ext_gpio_bank, attached with bind below.
module egp_checker #(
    parameter int NPINS  = 8,
    parameter int SER_W  = 4,
    parameter int SER_LO = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] odrn_q,
    input logic [NPINS-1:0] wake_q,
    input logic [NPINS-1:0] sticky,
    input logic [NPINS-1:0] edge_hit,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             ser_en,
    input logic [SER_W-1:0] ser_oe,
    input logic             wake_n
);
    localparam logic [NPINS-1:0] SER_MASK = NPINS'((2 ** SER_W - 1) << SER_LO);

    logic [NPINS-1:0] gpio_own;
    logic [NPINS-1:0] ser_oe_w;
    logic             clr_wr;

    // Helper terms for the properties.
    always_comb begin
        gpio_own = ~(SER_MASK & {NPINS{ser_en}});
        ser_oe_w = NPINS'(ser_oe) << SER_LO;
        clr_wr   = reg_we && (reg_addr == 3'd6);
    end

    // R3
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~dir_q & gpio_own) == '0));

    // R4
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & odrn_q & gpio_own) == '0));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_wr) |-> (($past(sticky) & ~sticky) == '0));

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_hit) != '0) |-> (($past(edge_hit) & ~sticky) == '0));

    // R9
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_n |-> (wake_q != '0));

    // R10
    ser_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> ((pad_oe & SER_MASK) == (ser_oe_w & SER_MASK)));
endmodule

bind ext_gpio_bank egp_checker #(.NPINS(NPINS), .SER_W(SER_W), .SER_LO(SER_LO)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .dir_q    (dir_q),
    .odrn_q   (odrn_q),
    .wake_q   (wake_q),
    .sticky   (sticky),
    .edge_hit (edge_hit),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .ser_en   (ser_en),
    .ser_oe   (ser_oe),
    .wake_n   (wake_n)
);

// File: tb/ext_gpio_bank_tb.sv
// Self-checking bench: directed corners plus seeded random single-change steps.
module ext_gpio_bank_tb_top;
    localparam logic [7:0] SMASK = 8'b0111_1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic       ser_en = 1'b0;
    logic [3:0] ser_out = '0, ser_oe = '0;
    logic       wake_n;

    int n_chk = 0, n_fail = 0;

    // model state
    logic [7:0] m_reg [6];
    logic [7:0] m_sticky = '0, m_act = '0;

    always #4 clk = ~clk;

    ext_gpio_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .ser_en(ser_en), .ser_out(ser_out), .ser_oe(ser_oe),
        .wake_n(wake_n)
    );

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] f_act();
        return (pad_in ^ m_reg[2]) & ~(SMASK & {8{ser_en}});
    endfunction

    function automatic logic [7:0] f_stat();
        return (m_reg[3] & m_sticky) | (~m_reg[3] & m_act);
    endfunction

    function automatic logic [7:0] f_oe();
        logic [7:0] g = m_reg[0] & ~(m_reg[4] & m_reg[1]);
        logic [7:0] s = 8'(ser_oe) << 3;
        return ser_en ? ((g & ~SMASK) | (s & SMASK)) : g;
    endfunction

    function automatic logic [7:0] f_out();
        logic [7:0] g = m_reg[1] & ~m_reg[4];
        logic [7:0] s = 8'(ser_out) << 3;
        return ser_en ? ((g & ~SMASK) | (s & SMASK)) : g;
    endfunction

    // Compare all observable outputs with the model.
    task automatic check_all(input string tag);
        logic [7:0] d;
        #1;
        chk(pad_oe == f_oe(), {tag, " R3/R4/R10/R11 pad_oe"}, pad_oe, f_oe());
        chk(pad_out == f_out(), {tag, " R3/R4/R10/R11 pad_out"}, pad_out, f_out());
        chk(wake_n == ~|(f_stat() & m_reg[5]), {tag, " R9 wake_n"}, {7'b0, wake_n}, {7'b0, ~|(f_stat() & m_reg[5])});
        rd(3'd6, d);
        chk(d == f_stat(), {tag, " R5/R6/R7 status"}, d, f_stat());
    endtask

    // Let the synchronizer and detector settle, then fold the step into the model.
    task automatic settle();
        logic [7:0] a_new;
        repeat (4) @(negedge clk);
        a_new    = f_act();
        m_sticky = m_sticky | (m_reg[3] & a_new & ~m_act);
        m_act    = a_new;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 8'h00, "R1 reset register", d, 8'h00);
        end
        chk(pad_oe == 8'h00, "R1 reset pad_oe", pad_oe, 8'h00);
        chk(wake_n == 1'b1, "R1 reset wake_n", {7'b0, wake_n}, 8'h01);

        // R2: readback and ignored raw write
        wr(3'd2, 8'hA5); m_reg[2] = 8'hA5;
        wr(3'd7, 8'hFF);
        rd(3'd2, d); chk(d == 8'hA5, "R2 polarity readback", d, 8'hA5);
        rd(3'd0, d); chk(d == 8'h00, "R2 raw write ignored (dir)", d, 8'h00);
        chk(pad_oe == 8'h00, "R2 raw write ignored (pad_oe)", pad_oe, 8'h00);
        wr(3'd2, 8'h00); m_reg[2] = 8'h00;
        settle();

        // R8: edge and clear in the same cycle on pin 0, then R7 clear alone
        wr(3'd3, 8'h01); m_reg[3] = 8'h01;
        settle();
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_addr = 3'd6; reg_wdata = 8'h01; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        rd(3'd6, d); chk(d[0] == 1'b1, "R8 edge wins over clear", d, 8'h01);
        settle();
        pad_in[0] = 1'b0; settle();
        rd(3'd6, d); chk(d[0] == 1'b1, "R6 sticky holds after input drops", d, 8'h01);
        wr(3'd6, 8'h00);
        rd(3'd6, d); chk(d[0] == 1'b1, "R7 write 0 keeps bit", d, 8'h01);
        wr(3'd6, 8'h01);
        rd(3'd6, d); chk(d[0] == 1'b0, "R7 write 1 clears bit", d, 8'h00);
        m_sticky = '0; m_act = f_act();
        check_all("directed");

        // Random single-change steps
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 4);
            case (op)
                0: begin
                    logic [2:0] a = 3'($urandom);
                    logic [7:0] v = 8'($urandom);
                    wr(a, v);
                    if (a < 3'd6) m_reg[a] = v;
                    else if (a == 3'd6) m_sticky = m_sticky & ~v;
                end
                1: begin @(negedge clk); pad_in = 8'($urandom); end
                2: begin
                    @(negedge clk);
                    ser_en = ~ser_en; ser_out = 4'($urandom); ser_oe = 4'($urandom);
                end
                default: begin
                    logic [7:0] v = 8'($urandom);
                    wr(3'd6, v); m_sticky = m_sticky & ~v;
                end
            endcase
            settle();
            check_all("random");
            if (it % 16 == 0) begin
                rd(3'd7, d);
                chk(d == pad_in, "R5 raw synchronized pins", d, pad_in);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule